// File: doc/BRIEF.md
# Challenge-Response Authentication Command Controller

This block decodes the authentication command set behind a bit-serial slave port. The host clocks in command bytes and data bits one write slot at a time, least significant bit first. The block recognises three commands. One loads a 64-bit challenge. Two start a MAC computation: one places the device identifier in the message, the other places all ones in the identifier field. The block builds the 512-bit message from four parts: the secret, the challenge, the identifier field and a fixed padding constant. It then fires a one-cycle start to an external hash engine and waits for that engine's done pulse.

After a compute command the host sends eight write slots, which count as zero bits. It then issues read slots, and each one returns one bit of the 160-bit result, least significant bit first. The first compute command after power-up primes the block and may be abandoned after its eighth bit. Until that happens, challenge writes do not take effect, so an unprimed first authentication uses a zero challenge. A bus reset returns the decoder to the command-byte state at any point. An unknown command byte makes the block ignore the bus until the next bus reset.

Top module: `auth_mac_ctrl`

## Requirements
- R1: After `rst`, `rd_bit` is 1, `hash_start` is 0, the decoder waits for a command byte and the stored challenge is zero.
- R2: Command byte 0x0C (bits taken LSB first) is followed by 64 data bits, and data bit k becomes challenge bit k. The message on `hash_msg` is laid out as [511:448] secret, [447:384] challenge, [383:320] identifier field and [319:0] the padding constant, which is the 32-bit word 0x6A09E667 repeated ten times.
- R3: Write slots after the 64th challenge bit are ignored: they change neither the challenge nor `hash_start`.
- R4: Command 0x36 sets the identifier field to all ones.
- R5: Command 0x35 sets the identifier field to `dev_id`.
- R6: `hash_start` is high for exactly one cycle. That cycle is the one following the clock edge that samples the eighth bit of a compute command.
- R7: The first compute command after `rst` primes the block. A challenge write received before priming leaves the challenge unchanged.
- R8: After the compute command, eight write slots are consumed. Each later read slot then returns the next bit of the result captured on `hash_done`, starting from bit 0. `rd_bit` and `rd_ack` update on the clock edge that samples `rd_req`.
- R9: A read slot issued while the hash engine is busy returns 1 and does not advance the result bit position.
- R10: `bus_rst` aborts any command and returns the decoder to the command-byte state. A partly received challenge does not change the stored challenge.
- R11: An unrecognised command byte makes the block ignore all write slots until `bus_rst`, and its read slots return 1.
- R12: A read slot outside the readout phase returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| bus_rst | input | 1 | Bus reset pulse, aborts the current command |
| wr_valid | input | 1 | Write slot strobe |
| wr_bit | input | 1 | Bit value of the write slot |
| rd_req | input | 1 | Read slot strobe |
| rd_bit | output | 1 | Bit returned for the last read slot |
| rd_ack | output | 1 | Pulses when `rd_bit` holds a new read result |
| secret | input | 64 | Device secret |
| dev_id | input | 64 | Device identifier |
| hash_start | output | 1 | One-cycle start to the hash engine |
| hash_msg | output | 512 | Message block for the hash engine |
| hash_done | input | 1 | Hash engine completion pulse |
| hash_mac | input | 160 | Hash result, valid with `hash_done` |

## Verification
Most wrong internal states in this block stay hidden until a full 160-bit readout. A wrong challenge, a wrong identifier field, a missing priming step or a shifted bit index all produce a readout that differs from the model. So each scenario finishes with a complete readout, compared against a MAC computed from the message the bench expects. Decoder faults show up sooner: a wrong state after a command byte shows within one cycle as a missing or extra `hash_start` pulse. A read position that moves while the engine is busy shows in the very next read slot.

// File: rtl/auth_pkg.sv
package auth_pkg;

    localparam int CMD_W    = 8;
    localparam int SECRET_W = 64;
    localparam int CHAL_W   = 64;
    localparam int ID_W     = 64;
    localparam int MSG_W    = 512;
    localparam int MAC_W    = 160;
    localparam int PAD_W    = MSG_W - SECRET_W - CHAL_W - ID_W;
    localparam int PAD_WORD_W = 32;

    localparam logic [PAD_WORD_W-1:0] PAD_WORD = 32'h6A09_E667;
    localparam logic [PAD_W-1:0]      PAD_BITS = {(PAD_W / PAD_WORD_W){PAD_WORD}};

    localparam logic [CMD_W-1:0] OP_LOAD_CHAL = 8'h0C;
    localparam logic [CMD_W-1:0] OP_MAC_DEVID = 8'h35;
    localparam logic [CMD_W-1:0] OP_MAC_ONES  = 8'h36;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_CHAL,
        PH_ZERO,
        PH_READ,
        PH_IGNORE
    } phase_e;

    typedef enum logic [1:0] {
        OPK_CHAL,
        OPK_MAC_ONES,
        OPK_MAC_DEVID,
        OPK_UNKNOWN
    } op_kind_e;

    typedef struct packed {
        logic [SECRET_W-1:0] secret;
        logic [CHAL_W-1:0]   chal;
        logic [ID_W-1:0]     id_field;
        logic [PAD_W-1:0]    pad;
    } msg_t;

    function automatic op_kind_e classify_op(input logic [CMD_W-1:0] b);
        case (b)
            OP_LOAD_CHAL: return OPK_CHAL;
            OP_MAC_ONES:  return OPK_MAC_ONES;
            OP_MAC_DEVID: return OPK_MAC_DEVID;
            default:      return OPK_UNKNOWN;
        endcase
    endfunction

    function automatic logic is_compute(input op_kind_e k);
        return (k == OPK_MAC_ONES) || (k == OPK_MAC_DEVID);
    endfunction

endpackage

// File: rtl/auth_chal_rx.sv
module auth_chal_rx
    import auth_pkg::*;
#(
    parameter int W = CHAL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         commit_en,
    input  logic         bit_in,
    output logic [W-1:0] chal
);
    logic [W-2:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            chal  <= '0;
        end else begin
            if (shift_en) begin
                stage <= {bit_in, stage[W-2:1]};
            end
            if (commit_en) begin
                chal <= {bit_in, stage};
            end
        end
    end
endmodule

// File: rtl/auth_msg_build.sv
module auth_msg_build
    import auth_pkg::*;
(
    input  logic                use_devid,
    input  logic [SECRET_W-1:0] secret,
    input  logic [CHAL_W-1:0]   chal,
    input  logic [ID_W-1:0]     dev_id,
    output msg_t                msg
);
    logic [ID_W-1:0] id_field;

    for (genvar i = 0; i < ID_W; i++) begin : g_id
        assign id_field[i] = use_devid ? dev_id[i] : 1'b1;
    end

    assign msg.secret   = secret;
    assign msg.chal     = chal;
    assign msg.id_field = id_field;
    assign msg.pad      = PAD_BITS;
endmodule

// File: rtl/auth_mac_out.sv
module auth_mac_out
    import auth_pkg::*;
#(
    parameter int W = MAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         idx_clr,
    input  logic         rd_req,
    input  logic         rd_adv,
    output logic         rd_bit,
    output logic         rd_ack,
    output logic         rd_last
);
    localparam int IDX_W = $clog2(W);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(W - 1);

    logic [W-1:0]     mac_q;
    logic [IDX_W-1:0] idx;

    assign rd_last = (idx == IDX_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            mac_q  <= '0;
            idx    <= '0;
            rd_bit <= 1'b1;
            rd_ack <= 1'b0;
        end else begin
            if (load) begin
                mac_q <= load_val;
            end
            rd_ack <= rd_req;
            if (rd_req) begin
                rd_bit <= rd_adv ? mac_q[idx] : 1'b1;
            end
            if (idx_clr) begin
                idx <= '0;
            end else if (rd_adv && !rd_last) begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/auth_mac_ctrl.sv
module auth_mac_ctrl
    import auth_pkg::*;
#(
    parameter int ZERO_SLOTS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_rst,
    input  logic                wr_valid,
    input  logic                wr_bit,
    input  logic                rd_req,
    output logic                rd_bit,
    output logic                rd_ack,
    input  logic [SECRET_W-1:0] secret,
    input  logic [ID_W-1:0]     dev_id,
    output logic                hash_start,
    output logic [MSG_W-1:0]    hash_msg,
    input  logic                hash_done,
    input  logic [MAC_W-1:0]    hash_mac
);
    localparam int CNT_MAX = (CHAL_W > ZERO_SLOTS) ? CHAL_W : ZERO_SLOTS;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] CHAL_LAST = CNT_W'(CHAL_W - 1);
    localparam logic [CNT_W-1:0] ZERO_LAST = CNT_W'(ZERO_SLOTS - 1);

    phase_e           state;
    logic [CNT_W-1:0] cnt;
    logic [CMD_W-2:0] cmd_sr;
    logic             busy;
    logic             primed;
    logic             id_sel;

    logic [CMD_W-1:0] cmd_byte;
    op_kind_e         kind;
    logic             bit_in;
    logic             cmd_done;
    logic             start_now;
    logic             chal_shift;
    logic             chal_commit;
    logic             rd_adv;
    logic             rd_last;
    logic [CHAL_W-1:0] chal;
    msg_t             msg;

    assign cmd_byte    = {wr_bit, cmd_sr};
    assign kind        = classify_op(cmd_byte);
    assign bit_in      = wr_valid && !bus_rst;
    assign cmd_done    = (state == PH_CMD) && bit_in && (cnt == CMD_LAST);
    assign start_now   = cmd_done && is_compute(kind);
    assign chal_shift  = (state == PH_CHAL) && bit_in;
    assign chal_commit = chal_shift && (cnt == CHAL_LAST) && primed;
    assign rd_adv      = (state == PH_READ) && rd_req && !bus_rst && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PH_CMD;
            cnt        <= '0;
            cmd_sr     <= '0;
            primed     <= 1'b0;
            id_sel     <= 1'b0;
            hash_start <= 1'b0;
        end else begin
            hash_start <= start_now;
            if (bus_rst) begin
                state <= PH_CMD;
                cnt   <= '0;
            end else begin
                case (state)
                    PH_CMD: if (wr_valid) begin
                        cmd_sr <= {wr_bit, cmd_sr[CMD_W-2:1]};
                        if (cnt == CMD_LAST) begin
                            cnt <= '0;
                            case (kind)
                                OPK_CHAL: state <= PH_CHAL;
                                OPK_MAC_ONES, OPK_MAC_DEVID: begin
                                    state  <= PH_ZERO;
                                    primed <= 1'b1;
                                    id_sel <= (kind == OPK_MAC_DEVID);
                                end
                                default: state <= PH_IGNORE;
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_CHAL: if (wr_valid) begin
                        if (cnt == CHAL_LAST) begin
                            cnt   <= '0;
                            state <= PH_IGNORE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_ZERO: if (wr_valid) begin
                        if (cnt == ZERO_LAST) begin
                            cnt   <= '0;
                            state <= PH_READ;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_READ: if (rd_adv && rd_last) begin
                        state <= PH_IGNORE;
                    end
                    default: state <= PH_IGNORE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (start_now) begin
            busy <= 1'b1;
        end else if (hash_done) begin
            busy <= 1'b0;
        end
    end

    auth_chal_rx #(.W(CHAL_W)) u_chal (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (chal_shift),
        .commit_en (chal_commit),
        .bit_in    (wr_bit),
        .chal      (chal)
    );

    auth_msg_build u_msg (
        .use_devid (id_sel),
        .secret    (secret),
        .chal      (chal),
        .dev_id    (dev_id),
        .msg       (msg)
    );

    assign hash_msg = msg;

    auth_mac_out #(.W(MAC_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .load     (hash_done),
        .load_val (hash_mac),
        .idx_clr  (start_now),
        .rd_req   (rd_req),
        .rd_adv   (rd_adv),
        .rd_bit   (rd_bit),
        .rd_ack   (rd_ack),
        .rd_last  (rd_last)
    );
endmodule

// File: rtl/auth_mac_chk.sv
module auth_mac_chk
    import auth_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_rst,
    input logic             rd_req,
    input logic             rd_bit,
    input logic             rd_ack,
    input logic             hash_start,
    input logic [MSG_W-1:0] hash_msg,
    input logic [ID_W-1:0]  dev_id,
    input phase_e           state,
    input logic             busy,
    input logic             id_sel
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!hash_start && rd_bit && state == PH_CMD));

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hash_start |=> !hash_start);

    // R4
    id_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (hash_start && !id_sel) |-> (hash_msg[PAD_W +: ID_W] == {ID_W{1'b1}}));

    // R5
    id_dev_chk: assert property (@(posedge clk) disable iff (rst)
        (hash_start && id_sel) |-> (hash_msg[PAD_W +: ID_W] == dev_id));

    // R9
    busy_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && busy) |=> (rd_bit && rd_ack));

    // R10
    bus_abort_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (state == PH_CMD));

    // R11
    ignore_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_IGNORE && !bus_rst) |=> (state == PH_IGNORE && !hash_start));
endmodule

bind auth_mac_ctrl auth_mac_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_rst    (bus_rst),
    .rd_req     (rd_req),
    .rd_bit     (rd_bit),
    .rd_ack     (rd_ack),
    .hash_start (hash_start),
    .hash_msg   (hash_msg),
    .dev_id     (dev_id),
    .state      (state),
    .busy       (busy),
    .id_sel     (id_sel)
);

// File: tb/tb_auth_mac_ctrl.sv
module tb_auth_mac_ctrl;
    localparam logic [63:0] SECRET = 64'hC0FF_EE12_3456_789A;
    localparam logic [63:0] DEVID  = 64'h2800_0123_4567_89AB;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_rst = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_bit = 1'b0;
    logic         rd_req = 1'b0;
    logic         rd_bit;
    logic         rd_ack;
    logic         hash_start;
    logic [511:0] hash_msg;
    logic         hash_done;
    logic [159:0] hash_mac;

    int n_run = 0;
    int n_fail = 0;

    int           stub_lat = 10;
    int           stub_cnt = 0;
    logic [511:0] stub_cap = '0;

    always #10 clk = ~clk;

    auth_mac_ctrl dut (
        .clk(clk), .rst(rst), .bus_rst(bus_rst),
        .wr_valid(wr_valid), .wr_bit(wr_bit), .rd_req(rd_req),
        .rd_bit(rd_bit), .rd_ack(rd_ack),
        .secret(SECRET), .dev_id(DEVID),
        .hash_start(hash_start), .hash_msg(hash_msg),
        .hash_done(hash_done), .hash_mac(hash_mac)
    );

    function automatic logic [159:0] fold(input logic [511:0] m);
        return m[511:352] ^ m[351:192] ^ m[191:32] ^ {128'd0, m[31:0]};
    endfunction

    function automatic logic [159:0] exp_mac(input logic [63:0] ch, input logic use_id);
        logic [63:0] idf;
        idf = use_id ? DEVID : {64{1'b1}};
        return fold({SECRET, ch, idf, {10{32'h6A09_E667}}});
    endfunction

    // stub hash engine
    always @(posedge clk) begin
        if (hash_start) begin
            stub_cap <= hash_msg;
            stub_cnt <= stub_lat;
        end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 1;
        end
    end
    assign hash_done = (stub_cnt == 1);
    assign hash_mac  = fold(stub_cap);

    task automatic check(input bit ok, input string req,
                         input logic [159:0] act, input logic [159:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wbit(input logic b);
        wr_valid = 1'b1;
        wr_bit   = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) wbit(b[i]);
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) wbit(v[i]);
    endtask

    task automatic rd_slot(output logic b);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        b = rd_bit;
    endtask

    task automatic pulse_bus_rst();
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    task automatic wait_hash();
        while (stub_cnt != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_mac(output logic [159:0] v);
        logic b;
        for (int i = 0; i < 160; i++) begin
            rd_slot(b);
            v[i] = b;
        end
    endtask

    // compute command, checks the start pulse (R6)
    task automatic issue_compute(input logic [7:0] op, input int lat);
        stub_lat = lat;
        send_byte(op);
        check(hash_start === 1'b1, "R6 start high", {159'd0, hash_start}, 160'd1);
        @(negedge clk);
        check(hash_start === 1'b0, "R6 start one cycle", {159'd0, hash_start}, 160'd0);
    endtask

    task automatic full_auth(input logic [7:0] op, input logic [63:0] ch,
                             input int lat, input string req);
        logic [159:0] got;
        logic [159:0] exp;
        pulse_bus_rst();
        issue_compute(op, lat);
        wait_hash();
        send_byte(8'h00);
        read_mac(got);
        exp = exp_mac(ch, op == 8'h35);
        check(got === exp, req, got, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0]  c1;
        logic [63:0]  c2;
        logic [159:0] got;
        logic [159:0] exp;
        logic         b;
        void'($urandom(32'd2718));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rd_bit === 1'b1, "R1 rd_bit after reset", {159'd0, rd_bit}, 160'd1);
        check(hash_start === 1'b0, "R1 start after reset", {159'd0, hash_start}, 160'd0);

        // R12 idle read returns 1
        rd_slot(b);
        check(b === 1'b1 && rd_ack === 1'b1, "R12 idle read", {159'd0, b}, 160'd1);

        // R7: challenge write before priming is dropped, first auth uses zero
        pulse_bus_rst();
        send_byte(8'h0C);
        send_bits({$urandom(), $urandom()}, 64);
        full_auth(8'h36, 64'd0, 12, "R7 R1 R4 unprimed zero challenge");

        // R2 R3 R5: load challenge with extra bytes, then compute with id
        c1 = {$urandom(), $urandom()};
        pulse_bus_rst();
        send_byte(8'h0C);
        send_bits(c1, 64);
        send_byte(8'h36);
        check(hash_start === 1'b0, "R3 extra byte no start", {159'd0, hash_start}, 160'd0);
        send_byte(8'hFF);
        full_auth(8'h35, c1, 17, "R2 R3 R5 R8 challenge and device id");

        // R9: read while busy returns 1 and does not advance
        pulse_bus_rst();
        issue_compute(8'h36, 80);
        send_byte(8'h00);
        rd_slot(b);
        check(b === 1'b1, "R9 busy read returns 1", {159'd0, b}, 160'd1);
        rd_slot(b);
        check(b === 1'b1, "R9 busy read again", {159'd0, b}, 160'd1);
        wait_hash();
        read_mac(got);
        exp = exp_mac(c1, 1'b0);
        check(got === exp, "R9 R8 readout starts at bit 0", got, exp);

        // R10: abort after eighth bit, and partial challenge write
        pulse_bus_rst();
        issue_compute(8'h35, 9);
        pulse_bus_rst();
        send_byte(8'h0C);
        send_bits(64'h0123_4567_89AB_CDEF, 20);
        pulse_bus_rst();
        wait_hash();

        // R11: unknown command, then ignored traffic
        send_byte(8'hA5);
        send_byte(8'h0C);
        send_bits(64'hFFFF_0000_FFFF_0000, 64);
        send_byte(8'h35);
        check(hash_start === 1'b0, "R11 no start while ignoring", {159'd0, hash_start}, 160'd0);
        rd_slot(b);
        check(b === 1'b1, "R11 read while ignoring", {159'd0, b}, 160'd1);
        full_auth(8'h36, c1, 7, "R10 R11 challenge preserved");

        // R12: read during zero phase returns 1
        pulse_bus_rst();
        issue_compute(8'h35, 5);
        wait_hash();
        send_bits(64'd0, 3);
        rd_slot(b);
        check(b === 1'b1, "R12 read in zero phase", {159'd0, b}, 160'd1);
        send_bits(64'd0, 5);
        read_mac(got);
        exp = exp_mac(c1, 1'b1);
        check(got === exp, "R8 readout after zero phase", got, exp);

        // random mix
        for (int it = 0; it < 6; it++) begin
            logic [7:0] op;
            c2 = {$urandom(), $urandom()};
            op = ($urandom() % 2 == 0) ? 8'h35 : 8'h36;
            pulse_bus_rst();
            send_byte(8'h0C);
            send_bits(c2, 64);
            full_auth(op, c2, 3 + int'($urandom() % 40), "R2 R4 R5 R8 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule